// File: doc/BRIEF.md
# Collision-Guarded Dual-Port RAM

A single-clock memory with two symmetric access ports, A and B. Each port can read or write any word in any cycle, and its read data arrives in a register one cycle after the access. Each port has its own choice of what its read register shows while that port is writing. The choice is set at build time by a mode parameter: the old word, the new word, or no update at all.

Because both ports reach the same storage, they can hit the same word in the same cycle. The block detects this case. When the arbitration option is built in, it settles the outcome deterministically: port A wins a double write, and a port that reads a word being written by the other port sees the stored value from before the write. A registered flag marks every such cycle, and a simulation message names the address and the two operations.

Typical uses are line buffers, shared tables between two engines, and synchronous FIFO storage, where the read-during-write result has to be known exactly.

Top module: `dpram_guarded`

## Requirements
- R1: An enabled read on either port returns, one clock later on that port's read output, the word last committed at its address; the two ports operate independently on any addresses.
- R2: While a port's enable is low, its read output keeps its value and its write enable has no effect on storage.
- R3: A port built with mode code 0 (old word) returns, after a write cycle, the word that was stored at that address before the write.
- R4: A port built with mode code 1 (new word) returns, after a write cycle, the data it wrote.
- R5: A port built with mode code 2 (hold) keeps its read output unchanged through a write cycle.
- R6: A collision is a cycle in which both ports are enabled on the same address and at least one of them writes; the collision flag is high in exactly the cycle after each collision and low otherwise.
- R7: With arbitration enabled, a double write to one address stores port A's data and discards port B's.
- R8: With arbitration enabled, a port reading an address that the other port writes in the same cycle receives the word stored before that write.
- R9: With arbitration disabled, collisions are still flagged. Only the contents of the word involved in a double write are unspecified, and all other accesses behave as in R1 to R5.
- R10: After reset both read outputs are zero and the collision flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Active-low reset of read registers and flag |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable, qualified by a_en |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable, qualified by b_en |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| coll_flag | output | 1 | High for one cycle after a collision |

## Verification
A wrong stored word stays hidden until some port reads that address, so the bench reads back every word it relies on, and it provokes collisions by crowding both ports into eight addresses. A wrong read-register update shows on the next clock edge, as do a missing hold or a wrong mode selection. A mistake in the collision detection shows in the flag one cycle after the access. A mistake in the arbitration shows only on a later read of the contested word, which the directed cases perform immediately.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

   // What a port's read register shows after a cycle in which that port writes
   typedef enum logic [1:0] {
      RDW_READ_FIRST  = 2'd0,
      RDW_WRITE_FIRST = 2'd1,
      RDW_HOLD        = 2'd2
   } rdw_mode_e;

endpackage

// File: rtl/dpram_rdport.sv
module dpram_rdport
   import dpram_pkg::*;
#(
   parameter int        DATA_W = 8,
   parameter rdw_mode_e MODE   = RDW_READ_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] rdata
);

   logic              load;
   logic [DATA_W-1:0] next_val;

   generate
      if (MODE == RDW_WRITE_FIRST) begin : g_wf
         assign load     = en;
         assign next_val = we ? wdata : word;
         assert_wf_new_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (en && we) |=> (rdata == $past(wdata)));
      end else if (MODE == RDW_HOLD) begin : g_hold
         assign load     = en & ~we;
         assign next_val = word;
         assert_hold_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (en && we) |=> $stable(rdata));
      end else begin : g_rf
         assign load     = en;
         assign next_val = word;
         assert_rf_old_R3: assert property (@(posedge clk) disable iff (!rst_n)
            en |=> (rdata == $past(word)));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata <= '0;
      else if (load) rdata <= next_val;
   end

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(rdata));

endmodule

// File: rtl/dpram_collide.sv
module dpram_collide #(
   parameter int ADDR_W  = 5,
   parameter bit WARN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_en,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              b_en,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   output logic              same_addr,
   output logic              coll_flag
);

   logic coll_now;

   assign same_addr = (a_addr == b_addr);
   assign coll_now  = a_en & b_en & same_addr & (a_we | b_we);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) coll_flag <= 1'b0;
      else        coll_flag <= coll_now;
   end

   // Simulation notice for every collision; carries no hardware
   always_ff @(posedge clk) begin
      if (WARN_EN && rst_n && coll_now)
         $display("[dpram] collision at addr %0h: A %s, B %s", a_addr,
                  a_we ? "write" : "read", b_we ? "write" : "read");
   end

endmodule

// File: rtl/dpram_guarded.sv
module dpram_guarded
   import dpram_pkg::*;
#(
   parameter int        DATA_W  = 8,
   parameter int        ADDR_W  = 5,
   parameter rdw_mode_e MODE_A  = RDW_READ_FIRST,
   parameter rdw_mode_e MODE_B  = RDW_WRITE_FIRST,
   parameter bit        ARB_EN  = 1'b1,
   parameter bit        WARN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_en,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_en,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              coll_flag
);

   localparam int DEPTH = 1 << ADDR_W;

   initial begin : elab_checks
      assert (DATA_W >= 1) else $error("dpram_guarded: DATA_W must be at least 1");
      assert (ADDR_W >= 1 && ADDR_W <= 12) else $error("dpram_guarded: ADDR_W out of range");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic              a_wr, b_wr, b_commit, same_addr;
   logic [DATA_W-1:0] a_word, b_word;

   assign a_wr   = a_en & a_we;
   assign b_wr   = b_en & b_we;
   assign a_word = mem[a_addr];
   assign b_word = mem[b_addr];

   dpram_collide #(.ADDR_W(ADDR_W), .WARN_EN(WARN_EN)) u_coll (
      .clk(clk), .rst_n(rst_n),
      .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
      .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
      .same_addr(same_addr), .coll_flag(coll_flag)
   );

   generate
      if (ARB_EN) begin : g_arb
         assign b_commit = b_wr & ~(a_wr & same_addr);
         assert_a_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (a_wr && b_wr && (a_addr == b_addr)) |-> !b_commit);
      end else begin : g_noarb
         assign b_commit = b_wr;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (b_commit) mem[b_addr] <= b_wdata;
      if (a_wr)     mem[a_addr] <= a_wdata;
   end

   dpram_rdport #(.DATA_W(DATA_W), .MODE(MODE_A)) u_rd_a (
      .clk(clk), .rst_n(rst_n), .en(a_en), .we(a_we),
      .wdata(a_wdata), .word(a_word), .rdata(a_rdata)
   );

   dpram_rdport #(.DATA_W(DATA_W), .MODE(MODE_B)) u_rd_b (
      .clk(clk), .rst_n(rst_n), .en(b_en), .we(b_we),
      .wdata(b_wdata), .word(b_word), .rdata(b_rdata)
   );

   assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && b_en && (a_addr == b_addr) && (a_we || b_we)) |=> coll_flag);
   assert_flag_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_en && b_en && (a_addr == b_addr) && (a_we || b_we)) |=> !coll_flag);

endmodule

// File: tb/tb_dpram_guarded.sv
module tb_dpram_guarded;
   timeunit 1ns; timeprecision 1ps;
   import dpram_pkg::*;

   localparam int DW = 8;
   localparam int AW = 5;
   localparam int N  = 1 << AW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic [DW-1:0] a_wdata = '0, b_wdata = '0;
   logic [DW-1:0] a_rd1, b_rd1, a_rd2, b_rd2;
   logic cf1, cf2;

   int tests = 0, fails = 0;

   always #2.5 clk = ~clk;

   // A: old word, B: new word, arbitration on
   dpram_guarded #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(RDW_READ_FIRST),
                   .MODE_B(RDW_WRITE_FIRST), .ARB_EN(1'b1), .WARN_EN(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
      .a_wdata(a_wdata), .a_rdata(a_rd1), .b_en(b_en), .b_we(b_we),
      .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rd1), .coll_flag(cf1));

   // Both hold mode, arbitration off
   dpram_guarded #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(RDW_HOLD),
                   .MODE_B(RDW_HOLD), .ARB_EN(1'b0), .WARN_EN(1'b0)) dut_nc (
      .clk(clk), .rst_n(rst_n), .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
      .a_wdata(a_wdata), .a_rdata(a_rd2), .b_en(b_en), .b_we(b_we),
      .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rd2), .coll_flag(cf2));

   // Bench models: stored words plus a "known" bit per word
   logic [DW-1:0] m1 [N];
   logic [DW-1:0] m2 [N];
   bit            k1 [N];
   bit            k2 [N];
   logic [DW-1:0] e1a = '0, e1b = '0, e2a = '0, e2b = '0;
   bit            v1a = 1, v1b = 1, v2a = 1, v2b = 1;

   task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(bit en, bit we, bit coll, rdw_mode_e m, bit arb);
      if (!en)         return "R2";
      if (coll && !arb) return "R9";
      if (we) begin
         if (m == RDW_READ_FIRST)  return "R3";
         if (m == RDW_WRITE_FIRST) return "R4";
         return "R5";
      end
      if (coll) return "R8";
      return "R1";
   endfunction

   // One clock: predict, advance, compare
   task automatic step();
      bit aw, bw, same, coll;
      string t1a, t1b, t2a, t2b;
      aw   = a_en && a_we;
      bw   = b_en && b_we;
      same = (a_addr == b_addr);
      coll = a_en && b_en && same && (a_we || b_we);
      t1a = tag_of(a_en, a_we, coll, RDW_READ_FIRST, 1'b1);
      t1b = tag_of(b_en, b_we, coll, RDW_WRITE_FIRST, 1'b1);
      t2a = tag_of(a_en, a_we, coll, RDW_HOLD, 1'b0);
      t2b = tag_of(b_en, b_we, coll, RDW_HOLD, 1'b0);
      if (aw && bw && same) t1a = "R7";
      // reads (old contents)
      if (a_en) begin e1a = m1[a_addr]; v1a = k1[a_addr]; end
      if (b_en) begin
         if (b_we) begin e1b = b_wdata; v1b = 1; end
         else begin e1b = m1[b_addr]; v1b = k1[b_addr]; end
      end
      if (a_en && !a_we) begin e2a = m2[a_addr]; v2a = k2[a_addr]; end
      if (b_en && !b_we) begin e2b = m2[b_addr]; v2b = k2[b_addr]; end
      // writes: arbitrated instance, A wins
      if (bw) begin m1[b_addr] = b_wdata; k1[b_addr] = 1; end
      if (aw) begin m1[a_addr] = a_wdata; k1[a_addr] = 1; end
      // writes: unarbitrated instance, double write leaves word unspecified
      if (aw && bw && same) k2[a_addr] = 0;
      else begin
         if (bw) begin m2[b_addr] = b_wdata; k2[b_addr] = 1; end
         if (aw) begin m2[a_addr] = a_wdata; k2[a_addr] = 1; end
      end
      @(posedge clk);
      #1;
      if (v1a) chk(t1a, "dut a_rdata", a_rd1, e1a);
      if (v1b) chk(t1b, "dut b_rdata", b_rd1, e1b);
      if (v2a) chk(t2a, "dut_nc a_rdata", a_rd2, e2a);
      if (v2b) chk(t2b, "dut_nc b_rdata", b_rd2, e2b);
      chk("R6", "dut coll_flag", {{(DW-1){1'b0}}, cf1}, {{(DW-1){1'b0}}, coll});
      chk("R9", "dut_nc coll_flag", {{(DW-1){1'b0}}, cf2}, {{(DW-1){1'b0}}, coll});
   endtask

   task automatic drive(bit ae, bit awe, int aa, int ad, bit be, bit bwe, int ba, int bd);
      a_en = ae; a_we = awe; a_addr = AW'(aa); a_wdata = DW'(ad);
      b_en = be; b_we = bwe; b_addr = AW'(ba); b_wdata = DW'(bd);
   endtask

   initial begin : watchdog
      #(5ns * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd2718));
      for (int i = 0; i < N; i++) begin k1[i] = 0; k2[i] = 0; m1[i] = '0; m2[i] = '0; end
      repeat (3) @(posedge clk);
      #1;
      // R10: reset values
      chk("R10", "a_rdata after reset", a_rd1, '0);
      chk("R10", "b_rdata after reset", b_rd1, '0);
      chk("R10", "coll_flag after reset", {{(DW-1){1'b0}}, cf1}, '0);
      chk("R10", "dut_nc b_rdata after reset", b_rd2, '0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      // Fill all words through A, B idle with write enable high (R2)
      for (int i = 0; i < N; i++) begin
         drive(1, 1, i, i * 3 + 1, 0, 1, i, 8'hEE);
         step();
      end
      // R1: independent reads
      drive(1, 0, 4, 0, 1, 0, 9, 0); step();
      drive(1, 0, 31, 0, 1, 0, 0, 0); step();
      // R7: double write, then read the word back on both ports
      drive(1, 1, 5, 8'hAA, 1, 1, 5, 8'h55); step();
      drive(1, 0, 5, 0, 1, 0, 5, 0); step();
      // R8: A reads word 6 while B writes it; then read again
      drive(1, 0, 6, 0, 1, 1, 6, 8'h3C); step();
      drive(1, 0, 6, 0, 0, 0, 0, 0); step();
      // R8 reversed: B reads word 7 while A writes it
      drive(1, 1, 7, 8'hC3, 1, 0, 7, 0); step();
      drive(0, 0, 0, 0, 1, 0, 7, 0); step();
      // R2: disabled port with write enable high must not write
      drive(0, 1, 8, 8'h99, 0, 1, 8, 8'h77); step();
      drive(1, 0, 8, 0, 1, 0, 8, 0); step();
      // Random traffic crowded into eight addresses
      for (int n = 0; n < 3000; n++) begin
         drive(($urandom_range(0, 3) != 0), $urandom_range(0, 1),
               int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
               ($urandom_range(0, 3) != 0), $urandom_range(0, 1),
               int'($urandom_range(0, 7)), int'($urandom_range(0, 255)));
         step();
      end
      drive(0, 0, 0, 0, 0, 0, 0, 0); step();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule